// File: doc/BRIEF.md
# Relative Branch Resolver

This block sits beside the fetch stage of a small 16-bit processor. Each cycle it looks at one instruction word, the program counter and the three condition flags. From these it decides whether a PC-relative branch is taken and which address fetch should use next. An instruction whose low nibble marks it as a branch carries a four-bit condition selector in its top nibble and a signed byte displacement in the middle. The displacement counts instructions, so it is scaled by two bytes. The PC presented to the block already points past the branch.

Ten condition selectors are defined. Two are unconditional: always and never. Six test one flag either set or clear. Two combine carry and zero to give unsigned greater-than and less-or-equal after a compare. A branch-class word with a selector outside that set is reported as an invalid instruction, and such a word never redirects fetch. The block only reads the flags and produces no new flag values. All three results are registered, so they appear one clock after the inputs are sampled.

Top module: `relbr_unit`

## Requirements
- R1: A word is a branch only when bits 3..0 equal 4'hE. For any other word, the registered outputs are taken=0, invalid=0 and next_pc equal to the sampled PC.
- R2: Bits 11..4 hold a two's-complement displacement. A taken branch gives next_pc = pc + (sign-extended displacement × 2), wrapping modulo 2^16.
- R3: Selector (bits 15..12) 0 is always taken and selector 1 is never taken.
- R4: Selector 2 is taken when Z=1. Selector 3 is taken when Z=0.
- R5: Selector 4 is taken when N=1. Selector 5 is taken when N=0.
- R6: Selector 6 is taken when C=1. Selector 7 is taken when C=0.
- R7: Selector 8 is taken when C=0 and Z=0. Selector 9 is taken when C=1 or Z=1.
- R8: For a branch word with selector 10..15, invalid=1, taken=0 and next_pc equals the sampled PC.
- R9: A branch-class word that is defined but not taken gives next_pc equal to the sampled PC.
- R10: The outputs change only on a rising clock edge and reflect the inputs sampled at that edge. A synchronous active-high reset forces all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 16 | Instruction word under evaluation |
| pc_i | input | 16 | Address of the instruction after this one |
| flag_n_i | input | 1 | Negative flag |
| flag_c_i | input | 1 | Carry flag |
| flag_z_i | input | 1 | Zero flag |
| taken_o | output | 1 | Branch redirects fetch (registered) |
| next_pc_o | output | 16 | Address fetch should use next (registered) |
| invalid_o | output | 1 | Undefined branch selector seen (registered) |

## Verification
Each of the three outputs passes through exactly one register, so every result is due on the first rising edge after its inputs are sampled. The bench changes inputs on the falling edge, checks one time unit after the next rising edge, and compares against a model of that same stimulus. Before each edge it also confirms that the outputs still hold the previous result, which shows that the result does not arrive early.

// File: rtl/relbr_pkg.sv
package relbr_pkg;

  // Condition selector values; the numeric order is architectural.
  typedef enum logic [3:0] {
    SEL_ALWAYS = 4'd0,
    SEL_NEVER  = 4'd1,
    SEL_ZSET   = 4'd2,
    SEL_ZCLR   = 4'd3,
    SEL_NSET   = 4'd4,
    SEL_NCLR   = 4'd5,
    SEL_CSET   = 4'd6,
    SEL_CCLR   = 4'd7,
    SEL_UGT    = 4'd8,
    SEL_ULE    = 4'd9
  } sel_e;

  localparam int unsigned SEL_COUNT = 10;
  localparam logic [3:0]  BR_CLASS  = 4'hE;

  // Evaluate one selector against the flags.
  function automatic logic sel_hit(input int unsigned idx,
                                   input logic n, input logic c, input logic z);
    case (idx)
      0:       sel_hit = 1'b1;
      1:       sel_hit = 1'b0;
      2:       sel_hit = z;
      3:       sel_hit = ~z;
      4:       sel_hit = n;
      5:       sel_hit = ~n;
      6:       sel_hit = c;
      7:       sel_hit = ~c;
      8:       sel_hit = ~c & ~z;
      9:       sel_hit = c | z;
      default: sel_hit = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/relbr_decode.sv
module relbr_decode #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CLS_W  = 4,
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned DISP_W = 8
) (
  input  logic [WORD_W-1:0] instr_i,
  output logic              is_branch_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [DISP_W-1:0] disp_o
);
  import relbr_pkg::*;

  localparam int unsigned DISP_LSB = CLS_W;
  localparam int unsigned SEL_LSB  = WORD_W - SEL_W;

  assign is_branch_o = (instr_i[CLS_W-1:0] == CLS_W'(BR_CLASS));
  assign sel_o       = instr_i[SEL_LSB +: SEL_W];
  assign disp_o      = instr_i[DISP_LSB +: DISP_W];

endmodule

// File: rtl/relbr_cond.sv
module relbr_cond #(
  parameter int unsigned SEL_W  = 4,
  parameter int unsigned NUM_SEL = 10
) (
  input  logic             is_branch_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             n_i,
  input  logic             c_i,
  input  logic             z_i,
  output logic             taken_o,
  output logic             invalid_o
);
  import relbr_pkg::*;

  localparam int unsigned TBL_W = 1 << SEL_W;

  logic [TBL_W-1:0] hit_vec;
  logic             defined;

  // One slot per possible selector; undefined slots read as zero.
  for (genvar g = 0; g < TBL_W; g++) begin : g_sel
    if (g < NUM_SEL) begin : g_def
      assign hit_vec[g] = sel_hit(g, n_i, c_i, z_i);
    end else begin : g_undef
      assign hit_vec[g] = 1'b0;
    end
  end

  assign defined   = (sel_i < SEL_W'(NUM_SEL));
  assign taken_o   = is_branch_i & defined & hit_vec[sel_i];
  assign invalid_o = is_branch_i & ~defined;

endmodule

// File: rtl/relbr_target.sv
module relbr_target #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [WORD_W-1:0] pc_i,
  input  logic [DISP_W-1:0] disp_i,
  output logic [WORD_W-1:0] target_o
);

  localparam int unsigned EXT_W = WORD_W - DISP_W;

  logic [WORD_W-1:0] disp_ext;
  logic [WORD_W-1:0] disp_bytes;

  assign disp_ext   = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
  assign disp_bytes = {disp_ext[WORD_W-2:0], 1'b0};
  assign target_o   = pc_i + disp_bytes;

endmodule

// File: rtl/relbr_unit.sv
module relbr_unit #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned CLS_W   = 4,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned DISP_W  = 8,
  parameter int unsigned NUM_SEL = relbr_pkg::SEL_COUNT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] instr_i,
  input  logic [WORD_W-1:0] pc_i,
  input  logic              flag_n_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  output logic              taken_o,
  output logic [WORD_W-1:0] next_pc_o,
  output logic              invalid_o
);

  logic              is_br;
  logic [SEL_W-1:0]  sel;
  logic [DISP_W-1:0] disp;
  logic              take_c;
  logic              inval_c;
  logic [WORD_W-1:0] target_c;
  logic [WORD_W-1:0] next_c;

  relbr_decode #(
    .WORD_W(WORD_W), .CLS_W(CLS_W), .SEL_W(SEL_W), .DISP_W(DISP_W)
  ) u_dec (
    .instr_i(instr_i), .is_branch_o(is_br), .sel_o(sel), .disp_o(disp)
  );

  relbr_cond #(
    .SEL_W(SEL_W), .NUM_SEL(NUM_SEL)
  ) u_cond (
    .is_branch_i(is_br), .sel_i(sel),
    .n_i(flag_n_i), .c_i(flag_c_i), .z_i(flag_z_i),
    .taken_o(take_c), .invalid_o(inval_c)
  );

  relbr_target #(
    .WORD_W(WORD_W), .DISP_W(DISP_W)
  ) u_tgt (
    .pc_i(pc_i), .disp_i(disp), .target_o(target_c)
  );

  assign next_c = take_c ? target_c : pc_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      invalid_o <= 1'b0;
      next_pc_o <= '0;
    end else begin
      taken_o   <= take_c;
      invalid_o <= inval_c;
      next_pc_o <= next_c;
    end
  end

endmodule

// File: rtl/relbr_unit_chk.sv
module relbr_unit_chk #(
  parameter int unsigned WORD_W  = 16,
  parameter int unsigned CLS_W   = 4,
  parameter int unsigned SEL_W   = 4,
  parameter int unsigned NUM_SEL = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [WORD_W-1:0] instr_i,
  input logic [WORD_W-1:0] pc_i,
  input logic              taken_o,
  input logic [WORD_W-1:0] next_pc_o,
  input logic              invalid_o
);

  logic             br_w;
  logic [SEL_W-1:0] sel_w;
  assign br_w  = (instr_i[CLS_W-1:0] == CLS_W'(4'hE));
  assign sel_w = instr_i[WORD_W-1 -: SEL_W];

  // R8: an undefined selector never redirects fetch
  assert_inval_not_taken_R8: assert property (@(posedge clk) disable iff (rst)
    !(invalid_o && taken_o));

  // R8
  assert_inval_flag_R8: assert property (@(posedge clk) disable iff (rst)
    (br_w && sel_w >= SEL_W'(NUM_SEL)) |=> (invalid_o && next_pc_o == $past(pc_i)));

  // R1
  assert_non_branch_R1: assert property (@(posedge clk) disable iff (rst)
    !br_w |=> (!taken_o && !invalid_o && next_pc_o == $past(pc_i)));

  // R3: selector 0 always redirects
  assert_always_R3: assert property (@(posedge clk) disable iff (rst)
    (br_w && sel_w == '0) |=> taken_o);

  // R3, R9: selector 1 falls through
  assert_never_R3: assert property (@(posedge clk) disable iff (rst)
    (br_w && sel_w == SEL_W'(1)) |=> (!taken_o && next_pc_o == $past(pc_i)));

  // R10: reset clears every output
  assert_reset_R10: assert property (@(posedge clk)
    rst |=> (!taken_o && !invalid_o && next_pc_o == '0));

endmodule

bind relbr_unit relbr_unit_chk #(
  .WORD_W(WORD_W), .CLS_W(CLS_W), .SEL_W(SEL_W), .NUM_SEL(NUM_SEL)
) u_chk (
  .clk(clk), .rst(rst), .instr_i(instr_i), .pc_i(pc_i),
  .taken_o(taken_o), .next_pc_o(next_pc_o), .invalid_o(invalid_o)
);

// File: tb/sim_relbr_unit.sv
`timescale 1ns/1ps
module sim_relbr_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic [15:0] pc = 16'h0000;
  logic        fn = 1'b0, fc = 1'b0, fz = 1'b0;
  logic        taken;
  logic [15:0] next_pc;
  logic        invalid;

  int checks = 0;
  int errors = 0;

  logic        p_taken = 1'b0;
  logic        p_inv = 1'b0;
  logic [15:0] p_next = 16'h0000;

  always #2.5 clk = ~clk;

  relbr_unit u0 (
    .clk(clk), .rst(rst), .instr_i(instr), .pc_i(pc),
    .flag_n_i(fn), .flag_c_i(fc), .flag_z_i(fz),
    .taken_o(taken), .next_pc_o(next_pc), .invalid_o(invalid)
  );

  function automatic logic m_cond(input logic [3:0] s, input logic n, c, z);
    case (s)
      4'd0: return 1'b1;
      4'd1: return 1'b0;
      4'd2: return z;
      4'd3: return !z;
      4'd4: return n;
      4'd5: return !n;
      4'd6: return c;
      4'd7: return !c;
      4'd8: return !c && !z;
      4'd9: return c || z;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string m_tag(input logic [15:0] w);
    if (w[3:0] != 4'hE) return "R1";
    case (w[15:12])
      4'd0, 4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5: return "R5";
      4'd6, 4'd7: return "R6";
      4'd8, 4'd9: return "R7";
      default:    return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] p,
                       input logic n, input logic c, input logic z);
    logic br, inv, tk;
    logic [15:0] disp2, nx;
    @(negedge clk);
    instr = w; pc = p; fn = n; fc = c; fz = z;
    #1;
    // R10: nothing moves before the edge
    chk("R10", "early taken", {15'd0, taken}, {15'd0, p_taken});
    chk("R10", "early next_pc", next_pc, p_next);
    br    = (w[3:0] == 4'hE);
    inv   = br && (w[15:12] > 4'd9);
    tk    = br && !inv && m_cond(w[15:12], n, c, z);
    disp2 = {{7{w[11]}}, w[11:4], 1'b0};
    nx    = tk ? p + disp2 : p;
    @(posedge clk);
    #1;
    chk(m_tag(w), "taken", {15'd0, taken}, {15'd0, tk});
    chk(inv ? "R8" : "R1", "invalid", {15'd0, invalid}, {15'd0, inv});
    chk(tk ? "R2" : "R9", "next_pc", next_pc, nx);
    p_taken = tk; p_inv = inv; p_next = nx;
  endtask

  initial begin
    #1000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    chk("R10", "reset taken", {15'd0, taken}, 16'd0);
    chk("R10", "reset invalid", {15'd0, invalid}, 16'd0);
    chk("R10", "reset next_pc", next_pc, 16'd0);
    @(negedge clk);
    rst = 1'b0;

    // every selector against every flag combination
    for (int s = 0; s < 16; s++) begin
      for (int f = 0; f < 8; f++) begin
        apply({s[3:0], 8'h05, 4'hE}, 16'h4000, f[2], f[1], f[0]);
      end
    end
    // R2: displacement extremes and wrap
    apply({4'd0, 8'h7F, 4'hE}, 16'h1000, 1'b0, 1'b0, 1'b0);
    apply({4'd0, 8'h80, 4'hE}, 16'h1000, 1'b0, 1'b0, 1'b0);
    apply({4'd0, 8'h02, 4'hE}, 16'hFFFE, 1'b0, 1'b0, 1'b0);
    apply({4'd0, 8'hFF, 4'hE}, 16'h0000, 1'b0, 1'b0, 1'b0);
    // R1: other classes with branch-like upper bits
    for (int k = 0; k < 16; k++) begin
      if (k != 14) apply({4'd0, 8'h10, k[3:0]}, 16'h2222, 1'b1, 1'b1, 1'b1);
    end
    // random mix
    for (int i = 0; i < 1500; i++) begin
      logic [15:0] w;
      w = 16'($urandom);
      if (i % 2 == 0) w[3:0] = 4'hE;
      apply(w, 16'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    // R10: reset mid-run clears outputs
    apply({4'd0, 8'h11, 4'hE}, 16'h0100, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R10", "sync reset taken", {15'd0, taken}, 16'd0);
    chk("R10", "sync reset next_pc", next_pc, 16'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule